// File: doc/BRIEF.md
# I3C Target In-Band Interrupt Requester

This block sits on the target side of an I3C link. It raises an in-band interrupt when software asks for one. Software pulses a write strobe with a 2-bit mode value. The block then does the following, in order:

1. It checks at once whether an interrupt is allowed at all.
2. It waits for a legal moment on the bus.
3. It asks an external bus engine to drive the interrupt header.
4. It records the outcome as a 2-bit status code, sets a sticky status-updated flag and drops its pending indication.

A NACK from the active controller does not end the request. The block keeps the request pending and tries again at the next legal moment.

Three conditions forbid an attempt:
- no dynamic address is held, either never assigned or cleared by a reset-all-addresses command;
- interrupt requests are disabled by a disable-events command;
- the device has taken the controller role.

These conditions are sampled twice: when the request is taken and again just before the header would be driven. If any of them fails at either point, the request completes as "not attempted" without touching the bus.

In the only supported mode, the legal moment is whichever comes first:
- a programmable number of consecutive cycles with both bus lines high, or
- a START seen on the bus.

Bit serialization, command decoding and address assignment live outside this block and appear only as inputs.

Top module: `ibi_requester`

## Requirements
- R1: A write with mode 00 while idle and eligible (dyn_addr_ok=1, ibi_enable=1, ctrl_role=0) sets `req_pending` on the next edge. `hdr_req` is only ever high while `req_pending` is high.
- R2: While waiting, the block triggers on the first of two events: a `start_det` cycle, or a cycle with both lines high in which the bus-free count is at least `idle_limit`. `hdr_req` rises on the edge after the trigger cycle. The bus-free count is the number of consecutive edges with SDA and SCL high. It is cleared by low lines, by `start_det` and by every cycle with `hdr_req` high.
- R3: `hdr_done` with `hdr_ack`=1 while `hdr_req` is high completes the request on the next edge. On that edge the status becomes 01, the flag is set and `req_pending` and `hdr_req` drop.
- R4: `hdr_done` with `hdr_ack`=0 drops `hdr_req` on the next edge. `req_pending` stays high, the status and flag are unchanged, and the block retries at the next trigger.
- R5: A mode-00 write while any eligibility condition fails writes status 11 and sets the flag on the next edge. `req_pending` and `hdr_req` stay low.
- R6: If eligibility has failed when the trigger arrives, the request completes with status 11 instead of driving the header.
- R7: A write with mode 01, 10 or 11 completes on the next edge with status 11 and the flag set.
- R8: After reset the status is 00, and the flag, `req_pending` and `hdr_req` are 0. Status 10 is never produced.
- R9: The status-updated flag stays set until a `stat_clr` pulse clears it. A new update in the same cycle as `stat_clr` wins.
- R10: A write while `req_pending` is high has no effect on the status, the flag or the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Software write strobe for a request |
| req_mode | input | 2 | Request mode; 00 = bus-free-or-START |
| stat_clr | input | 1 | Write-one-to-clear for the status-updated flag |
| dyn_addr_ok | input | 1 | Dynamic address currently assigned |
| ibi_enable | input | 1 | Interrupt requests enabled by the controller |
| ctrl_role | input | 1 | Device is acting as controller |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| start_det | input | 1 | One-cycle START detection |
| idle_limit | input | IDLE_W | Bus-free threshold in cycles |
| hdr_done | input | 1 | Bus engine finished the header and acknowledge |
| hdr_ack | input | 1 | Acknowledge result, valid with hdr_done |
| hdr_req | output | 1 | Request to the bus engine to drive the header |
| req_pending | output | 1 | Request bit as seen by software |
| ibi_status | output | 2 | 00 none, 01 accepted, 11 not attempted |
| status_irq | output | 1 | Sticky status-updated flag |

## Verification
Every output comes straight from a register. The effect of an input sampled at one edge therefore appears exactly one edge later:
- a rejection, a completion or a NACK return shows one cycle after the write or the `hdr_done`;
- `hdr_req` shows one cycle after the trigger cycle;
- a bus-free trigger needs `idle_limit` high edges before that trigger cycle.

The bench drives inputs on the falling edge and advances a reference model at the rising edge. It compares all four outputs at the following falling edge, so every comparison lands in the cycle an output is due. Directed cases then confirm rejections, retries, ignored writes and START triggers at those same one-cycle offsets.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2
    } ibi_state_e;

    localparam logic [1:0] STS_NONE  = 2'b00;
    localparam logic [1:0] STS_ACK   = 2'b01;
    localparam logic [1:0] STS_SKIP  = 2'b11;
    localparam logic [1:0] MODE_AUTO = 2'b00;

    typedef struct packed {
        ibi_state_e state;
        logic [1:0] status;
        logic       irq;
    } ibi_regs_t;
endpackage

// File: rtl/ibi_idle_timer.sv
module ibi_idle_timer #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              start_det,
    input  logic              hold,
    input  logic [IDLE_W-1:0] limit,
    output logic              fire
);
    localparam logic [IDLE_W-1:0] CNT_MAX = {IDLE_W{1'b1}};

    logic [IDLE_W-1:0] cnt_d, cnt_q;
    logic              bus_high;

    assign bus_high = sda_in & scl_in;

    always_comb begin
        cnt_d = cnt_q;
        if (!bus_high || start_det || hold) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire = bus_high && (cnt_q >= limit);

    // R2: any bus activity restarts the bus-free count
    p_activity_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || !bus_high) |=> (cnt_q == '0));
endmodule

// File: rtl/ibi_gate.sv
module ibi_gate
    import ibi_pkg::*;
(
    input  logic       dyn_addr_ok,
    input  logic       ibi_enable,
    input  logic       ctrl_role,
    input  logic [1:0] req_mode,
    output logic       allowed,
    output logic       mode_ok
);
    assign allowed = dyn_addr_ok & ibi_enable & ~ctrl_role;
    assign mode_ok = (req_mode == MODE_AUTO);
endmodule

// File: rtl/ibi_requester.sv
module ibi_requester
    import ibi_pkg::*;
#(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [1:0]        req_mode,
    input  logic              stat_clr,
    input  logic              dyn_addr_ok,
    input  logic              ibi_enable,
    input  logic              ctrl_role,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              start_det,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              hdr_done,
    input  logic              hdr_ack,
    output logic              hdr_req,
    output logic              req_pending,
    output logic [1:0]        ibi_status,
    output logic              status_irq
);
    ibi_regs_t r_d, r_q;
    logic      allowed, mode_ok, idle_fire, trigger, upd;

    ibi_gate u_gate (
        .dyn_addr_ok (dyn_addr_ok),
        .ibi_enable  (ibi_enable),
        .ctrl_role   (ctrl_role),
        .req_mode    (req_mode),
        .allowed     (allowed),
        .mode_ok     (mode_ok)
    );

    ibi_idle_timer #(.IDLE_W(IDLE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .hold      (hdr_req),
        .limit     (idle_limit),
        .fire      (idle_fire)
    );

    assign trigger = start_det | idle_fire;

    always_comb begin
        r_d = r_q;
        upd = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_wr) begin
                    if (mode_ok && allowed) begin
                        r_d.state = ST_WAIT;
                    end else begin
                        r_d.status = STS_SKIP;
                        upd        = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (trigger) begin
                    if (allowed) begin
                        r_d.state = ST_DRIVE;
                    end else begin
                        r_d.state  = ST_IDLE;
                        r_d.status = STS_SKIP;
                        upd        = 1'b1;
                    end
                end
            end
            ST_DRIVE: begin
                if (hdr_done) begin
                    if (hdr_ack) begin
                        r_d.state  = ST_IDLE;
                        r_d.status = STS_ACK;
                        upd        = 1'b1;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.irq = upd | (r_q.irq & ~stat_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.status <= STS_NONE;
            r_q.irq    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hdr_req     = (r_q.state == ST_DRIVE);
    assign req_pending = (r_q.state != ST_IDLE);
    assign ibi_status  = r_q.status;
    assign status_irq  = r_q.irq;

    p_no_reserved_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ibi_status != 2'b10);

    p_hdr_needs_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req |-> req_pending);

    p_start_triggers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pending && !hdr_req && start_det && allowed) |=> hdr_req);

    p_ack_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_req && hdr_done && hdr_ack) |=>
            (!req_pending && ibi_status == STS_ACK && status_irq));

    p_nack_retries_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_req && hdr_done && !hdr_ack) |=>
            (req_pending && !hdr_req && $stable(ibi_status)));

    p_ineligible_skips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pending && req_wr && !allowed) |=>
            (ibi_status == STS_SKIP && status_irq && !req_pending));

    p_bad_mode_skips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pending && req_wr && req_mode != MODE_AUTO) |=>
            (ibi_status == STS_SKIP && status_irq && !req_pending));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_irq && !stat_clr) |=> status_irq);
endmodule

// File: tb/tb_ibi_requester.sv
module tb_ibi_requester;
    localparam int IDLE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wr = 0, stat_clr = 0, dyn_addr_ok = 1, ibi_enable = 1, ctrl_role = 0;
    logic sda_in = 1, scl_in = 1, start_det = 0, hdr_done = 0, hdr_ack = 0;
    logic [1:0] req_mode = 2'b00;
    logic [IDLE_W-1:0] idle_limit = 16'd4;
    logic hdr_req, req_pending, status_irq;
    logic [1:0] ibi_status;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int          m_state = 0;    // 0 idle, 1 waiting, 2 driving
    int unsigned m_cnt = 0;
    logic [1:0]  m_status = 2'b00;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ibi_requester #(.IDLE_W(IDLE_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mode(req_mode),
        .stat_clr(stat_clr), .dyn_addr_ok(dyn_addr_ok), .ibi_enable(ibi_enable),
        .ctrl_role(ctrl_role), .sda_in(sda_in), .scl_in(scl_in),
        .start_det(start_det), .idle_limit(idle_limit), .hdr_done(hdr_done),
        .hdr_ack(hdr_ack), .hdr_req(hdr_req), .req_pending(req_pending),
        .ibi_status(ibi_status), .status_irq(status_irq)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model written from the requirements: one step per rising edge.
    task automatic model_step();
        bit          bus_hi, fire, trig, ok, upd;
        int unsigned nxt_cnt;
        bus_hi = sda_in && scl_in;
        fire   = bus_hi && (m_cnt >= idle_limit);
        trig   = start_det || fire;
        ok     = dyn_addr_ok && ibi_enable && !ctrl_role;
        upd    = 0;
        if (!bus_hi || start_det || m_state == 2) nxt_cnt = 0;
        else if (m_cnt < 32'hFFFF) nxt_cnt = m_cnt + 1;
        else nxt_cnt = m_cnt;
        case (m_state)
            0: if (req_wr) begin
                   if (req_mode == 2'b00 && ok) m_state = 1;
                   else begin m_status = 2'b11; upd = 1; end
               end
            1: if (trig) begin
                   if (ok) m_state = 2;
                   else begin m_state = 0; m_status = 2'b11; upd = 1; end
               end
            default: if (hdr_done) begin
                   if (hdr_ack) begin m_state = 0; m_status = 2'b01; upd = 1; end
                   else m_state = 1;
               end
        endcase
        m_cnt = nxt_cnt;
        m_irq = upd || (m_irq && !stat_clr);
    endtask

    task automatic compare();
        chk(int'(hdr_req),     int'(m_state == 2), "R2 hdr_req");
        chk(int'(req_pending), int'(m_state != 0), "R1 req_pending");
        chk(int'(ibi_status),  int'(m_status),     "R3 ibi_status");
        chk(int'(status_irq),  int'(m_irq),        "R9 status_irq");
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_hdr();
        for (int i = 0; i < 60 && !hdr_req; i++) cycle();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset values
        chk(int'(ibi_status), 0, "R8 status after reset");
        chk(int'(status_irq), 0, "R8 irq after reset");
        chk(int'(req_pending), 0, "R8 pending after reset");
        chk(int'(hdr_req), 0, "R8 hdr_req after reset");
        rst_n = 1'b1;
        cycle();

        // R7: reserved mode
        req_wr = 1; req_mode = 2'b01; cycle(); req_wr = 0; req_mode = 2'b00;
        chk(int'(ibi_status), 3, "R7 reserved mode status");
        chk(int'(status_irq), 1, "R7 reserved mode flag");
        chk(int'(req_pending), 0, "R7 reserved mode pending");
        cycle();
        chk(int'(status_irq), 1, "R9 flag holds");
        stat_clr = 1; cycle(); stat_clr = 0;
        chk(int'(status_irq), 0, "R9 flag cleared");

        // R5: no dynamic address
        dyn_addr_ok = 0; req_wr = 1; cycle(); req_wr = 0; dyn_addr_ok = 1;
        chk(int'(ibi_status), 3, "R5 no address status");
        chk(int'(req_pending), 0, "R5 no address pending");
        chk(int'(hdr_req), 0, "R5 no header");
        stat_clr = 1; cycle(); stat_clr = 0;

        // R1, R10, R4, R3
        req_wr = 1; cycle(); req_wr = 0;
        chk(int'(req_pending), 1, "R1 pending set");
        chk(int'(hdr_req), 0, "R1 no header before trigger");
        wait_hdr();
        chk(int'(hdr_req), 1, "R2 bus-free trigger");
        req_wr = 1; req_mode = 2'b10; cycle(); req_wr = 0; req_mode = 2'b00;
        chk(int'(req_pending), 1, "R10 pending kept");
        chk(int'(ibi_status), 3, "R10 status unchanged");
        chk(int'(status_irq), 0, "R10 flag unchanged");
        hdr_done = 1; hdr_ack = 0; cycle(); hdr_done = 0;
        chk(int'(hdr_req), 0, "R4 header dropped on NACK");
        chk(int'(req_pending), 1, "R4 still pending");
        chk(int'(status_irq), 0, "R4 no update");
        wait_hdr();
        chk(int'(hdr_req), 1, "R4 retried");
        hdr_done = 1; hdr_ack = 1; cycle(); hdr_done = 0; hdr_ack = 0;
        chk(int'(ibi_status), 1, "R3 accepted status");
        chk(int'(req_pending), 0, "R3 pending cleared");
        chk(int'(status_irq), 1, "R3 flag set");
        // R9: set wins over clear
        req_wr = 1; req_mode = 2'b11; stat_clr = 1; cycle();
        req_wr = 0; req_mode = 2'b00; stat_clr = 0;
        chk(int'(status_irq), 1, "R9 set wins over clear");
        stat_clr = 1; cycle(); stat_clr = 0;

        // R2: START trigger with a long bus-free limit
        idle_limit = 16'd100; sda_in = 0;
        req_wr = 1; cycle(); req_wr = 0;
        cycle();
        chk(int'(hdr_req), 0, "R2 no trigger yet");
        start_det = 1; cycle(); start_det = 0;
        chk(int'(hdr_req), 1, "R2 START trigger");
        hdr_done = 1; hdr_ack = 1; cycle(); hdr_done = 0; hdr_ack = 0;

        // R6: enable removed while waiting
        req_wr = 1; cycle(); req_wr = 0;
        ibi_enable = 0; start_det = 1; cycle(); start_det = 0; ibi_enable = 1;
        chk(int'(ibi_status), 3, "R6 status at trigger");
        chk(int'(req_pending), 0, "R6 pending cleared");
        chk(int'(hdr_req), 0, "R6 no header");
        sda_in = 1;

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) idle_limit = 16'($urandom % 10);
            req_wr      = ($urandom % 8) == 0;
            req_mode    = (($urandom % 4) == 0) ? 2'(1 + $urandom % 3) : 2'b00;
            stat_clr    = ($urandom % 6) == 0;
            dyn_addr_ok = ($urandom % 16) != 0;
            ibi_enable  = ($urandom % 16) != 0;
            ctrl_role   = ($urandom % 20) == 0;
            sda_in      = ($urandom % 10) != 0;
            scl_in      = ($urandom % 10) != 0;
            start_det   = ($urandom % 30) == 0;
            hdr_done    = hdr_req && (($urandom % 3) == 0);
            hdr_ack     = ($urandom % 2) == 0;
            cycle();
            chk(int'(ibi_status != 2'b10), 1, "R8 reserved code absent");
        end

        done = 1;
        report();
    end
endmodule